// File: doc/BRIEF.md
# Multichannel ADC Serial Readout Controller

This block sits on the host side of a simultaneous-sampling converter with six 14-bit channels and a serial data port. A one-cycle start request, together with a 3-bit channel-count code and a polarity-mode bit, begins a transaction. The block captures the code and the mode and drives them to the converter. If the mode differs from the previous transaction, it waits for a programmable acquisition time. It then pulses a convert strobe and generates a burst of serial clocks whose length depends on how many channels are active.

The converter moves its output on the rising edge of the generated clock. The block samples the data line on the falling edge. Each channel occupies a 16-bit slot. Its 14-bit result comes first, most significant bit first, and the two trailing bits are dropped. Every result word is presented with its channel index, a one-cycle valid strobe, and a flag that marks the word as two's complement (bipolar mode) or straight binary (unipolar mode). The controls stay frozen from the accepted start until the last word is delivered, and further start requests are ignored during that time.

Top module: `mcadc_readout_ctrl`

## Requirements
- R1: After reset, or at any time while reset is asserted, `busy_o`, `conv_o`, `sclk_o` and `word_valid_o` are low.
- R2: A start request sampled while idle raises `conv_o` in the next cycle, unless R11 applies. `conv_o` stays high for CONV_CYCLES clock cycles, and `sclk_o` stays low during that time.
- R3: The channel code selects codes+1 channels for codes 0 to 4 (code 0 gives channel 0 only). Codes 5, 6 and 7 all select six channels. Exactly one word is delivered per selected channel.
- R4: The serial burst has exactly 16 rising edges of `sclk_o` per selected channel. Each half period of `sclk_o` lasts SCLK_HALF clock cycles.
- R5: `sdata_i` is sampled when `sclk_o` falls. The converter is expected to change the line on the rising edge.
- R6: Within each 16-bit slot, the first 14 bits received, most significant first, form the word. The last two bits have no effect on it.
- R7: Words are tagged with channel indices 0, 1, 2 and so on, in ascending order. `word_valid_o` is high for exactly one cycle per word.
- R8: `word_twos_o` is 1 with every word of a bipolar-mode transaction (two's complement) and 0 with every word of a unipolar one (straight binary).
- R9: `sel_out_o` and `bip_out_o` keep the values captured at the accepted start while `busy_o` is high. A start request during busy has no effect on them, on the word count or on the data.
- R10: `busy_o` goes high in the cycle after the accepted start. It is still high in the cycle of the last `word_valid_o` and low in the following cycle.
- R11: When the requested polarity differs from the held one (0 after reset), `conv_o` rises ACQ_CYCLES cycles later than it otherwise would.
- R12: `conv_o` and `sclk_o` are never high together, and neither is high while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transaction start request |
| chan_sel_i | input | SEL_W | Channel-count code |
| bipolar_i | input | 1 | Requested polarity mode (1 = bipolar) |
| sdata_i | input | 1 | Serial data from the converter |
| conv_o | output | 1 | Convert strobe |
| sclk_o | output | 1 | Generated serial clock |
| sel_out_o | output | SEL_W | Frozen channel code driven to the converter |
| bip_out_o | output | 1 | Frozen polarity mode driven to the converter |
| busy_o | output | 1 | Transaction in progress |
| word_valid_o | output | 1 | Result word strobe |
| word_data_o | output | RES_BITS | Result word |
| word_chan_o | output | CH_W | Channel index of the word |
| word_twos_o | output | 1 | Word is two's complement (1) or straight binary (0) |

## Verification
Several properties are checked on every cycle: strobe and clock exclusivity, silence while idle, the frozen controls during busy, single-cycle valid pulses inside busy, the channel-index range, and the minimum gap between a polarity change and the next convert strobe. Some behaviours can only be shown by the bench's scenarios, which drive a converter model against the block. These are the exact burst length for each code, the falling-edge sample point, the discarding of the trailing slot bits, word values and order, the format flag, and the precise strobe latencies.

// File: rtl/mcadc_pkg.sv
package mcadc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ACQ  = 3'd1,
    ST_CONV = 3'd2,
    ST_READ = 3'd3,
    ST_DONE = 3'd4
  } rd_state_e;

  // Highest channel index converted for a given count code.
  function automatic int unsigned top_chan(input int unsigned code, input int unsigned nch);
    return (code >= nch - 1) ? nch - 1 : code;
  endfunction

endpackage

// File: rtl/mcadc_rst_sync.sv
module mcadc_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_o = hold_q;
endmodule

// File: rtl/mcadc_sclk_gen.sv
module mcadc_sclk_gen #(
  parameter int SCLK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sclk_o,
  output logic fall_o
);
  localparam int CW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic          flip;

  assign flip = run_i && (cnt_q == CW'(SCLK_HALF - 1));

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (!run_i) begin
      cnt_d = '0;
      lvl_d = 1'b0;
    end else if (flip) begin
      cnt_d = '0;
      lvl_d = ~lvl_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign sclk_o = lvl_q;
  assign fall_o = flip && lvl_q;
endmodule

// File: rtl/mcadc_timer.sv
module mcadc_timer #(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          done_o
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = load_val_i;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/mcadc_shift_rx.sv
module mcadc_shift_rx #(
  parameter int SLOT_BITS = 16,
  parameter int RES_BITS  = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear_i,
  input  logic                sample_i,
  input  logic                sdata_i,
  output logic [RES_BITS-1:0] word_o,
  output logic                slot_last_o
);
  localparam int BW = $clog2(SLOT_BITS);

  logic [BW-1:0]       bit_q, bit_d;
  logic [RES_BITS-1:0] shr_q, shr_d;
  logic                in_res;
  logic                at_end;

  assign in_res = (bit_q < BW'(RES_BITS));
  assign at_end = (bit_q == BW'(SLOT_BITS - 1));

  always_comb begin
    bit_d = bit_q;
    shr_d = shr_q;
    if (clear_i) begin
      bit_d = '0;
    end else if (sample_i) begin
      bit_d = at_end ? '0 : bit_q + 1'b1;
      if (in_res) shr_d = {shr_q[RES_BITS-2:0], sdata_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      shr_q <= '0;
    end else begin
      bit_q <= bit_d;
      shr_q <= shr_d;
    end
  end

  assign word_o      = shr_q;
  assign slot_last_o = sample_i && at_end;
endmodule

// File: rtl/mcadc_readout_ctrl.sv
module mcadc_readout_ctrl
  import mcadc_pkg::*;
#(
  parameter int NCH         = 6,
  parameter int SEL_W       = 3,
  parameter int SLOT_BITS   = 16,
  parameter int RES_BITS    = 14,
  parameter int SCLK_HALF   = 2,
  parameter int CONV_CYCLES = 2,
  parameter int ACQ_CYCLES  = 20,
  localparam int CH_W       = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [SEL_W-1:0]    chan_sel_i,
  input  logic                bipolar_i,
  input  logic                sdata_i,
  output logic                conv_o,
  output logic                sclk_o,
  output logic [SEL_W-1:0]    sel_out_o,
  output logic                bip_out_o,
  output logic                busy_o,
  output logic                word_valid_o,
  output logic [RES_BITS-1:0] word_data_o,
  output logic [CH_W-1:0]     word_chan_o,
  output logic                word_twos_o
);
  localparam int TMR_MAX = (ACQ_CYCLES > CONV_CYCLES) ? ACQ_CYCLES : CONV_CYCLES;
  localparam int TW      = $clog2(TMR_MAX + 1);

  logic                rst_i_n;
  rd_state_e           st_q, st_d;
  logic [SEL_W-1:0]    sel_q;
  logic                bip_q;
  logic [CH_W-1:0]     last_q, last_d;
  logic [CH_W-1:0]     chan_q, chan_d;
  logic                accept;
  logic                tmr_load, tmr_done;
  logic [TW-1:0]       tmr_val;
  logic                run, fall, slot_last;
  logic [RES_BITS-1:0] rx_word;
  logic                vld_q;
  logic [RES_BITS-1:0] data_q;
  logic [CH_W-1:0]     wch_q;
  logic                twos_q;

  mcadc_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_i_n)
  );

  mcadc_timer #(.TW(TW)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  mcadc_sclk_gen #(.SCLK_HALF(SCLK_HALF)) u_sclk (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .run_i  (run),
    .sclk_o (sclk_o),
    .fall_o (fall)
  );

  mcadc_shift_rx #(.SLOT_BITS(SLOT_BITS), .RES_BITS(RES_BITS)) u_rx (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .clear_i     (accept),
    .sample_i    (fall),
    .sdata_i     (sdata_i),
    .word_o      (rx_word),
    .slot_last_o (slot_last)
  );

  assign run = (st_q == ST_READ);

  // Sequencer next state
  always_comb begin
    st_d     = st_q;
    accept   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st_q)
      ST_IDLE: if (start_i) begin
        accept   = 1'b1;
        tmr_load = 1'b1;
        if (bipolar_i != bip_q) begin
          st_d    = ST_ACQ;
          tmr_val = TW'(ACQ_CYCLES - 1);
        end else begin
          st_d    = ST_CONV;
          tmr_val = TW'(CONV_CYCLES - 1);
        end
      end
      ST_ACQ: if (tmr_done) begin
        st_d     = ST_CONV;
        tmr_load = 1'b1;
        tmr_val  = TW'(CONV_CYCLES - 1);
      end
      ST_CONV: if (tmr_done) st_d = ST_READ;
      ST_READ: if (slot_last && (chan_q == last_q)) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    last_d = last_q;
    if (accept) last_d = CH_W'(top_chan(int'(chan_sel_i), NCH));
  end

  always_comb begin
    chan_d = chan_q;
    if (accept)         chan_d = '0;
    else if (slot_last) chan_d = chan_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ST_IDLE;
      sel_q  <= '0;
      bip_q  <= 1'b0;
      last_q <= '0;
      chan_q <= '0;
    end else begin
      st_q   <= st_d;
      last_q <= last_d;
      chan_q <= chan_d;
      if (accept) begin
        sel_q <= chan_sel_i;
        bip_q <= bipolar_i;
      end
    end
  end

  // Result word register
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      wch_q  <= '0;
      twos_q <= 1'b0;
    end else begin
      vld_q <= slot_last;
      if (slot_last) begin
        data_q <= rx_word;
        wch_q  <= chan_q;
        twos_q <= bip_q;
      end
    end
  end

  assign conv_o       = (st_q == ST_CONV);
  assign busy_o       = (st_q != ST_IDLE);
  assign sel_out_o    = sel_q;
  assign bip_out_o    = bip_q;
  assign word_valid_o = vld_q;
  assign word_data_o  = data_q;
  assign word_chan_o  = wch_q;
  assign word_twos_o  = twos_q;
endmodule

// File: rtl/mcadc_readout_ctrl_chk.sv
module mcadc_readout_ctrl_chk #(
  parameter int NCH        = 6,
  parameter int SEL_W      = 3,
  parameter int ACQ_CYCLES = 20,
  parameter int CH_W       = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             conv_o,
  input logic             sclk_o,
  input logic             busy_o,
  input logic             word_valid_o,
  input logic [CH_W-1:0]  word_chan_o,
  input logic [SEL_W-1:0] sel_out_o,
  input logic             bip_out_o
);
  localparam int GW = $clog2(ACQ_CYCLES + 1);

  logic [GW-1:0] gap_q;
  logic          bip_prev_q;
  logic [CH_W-1:0] max_ch;

  assign max_ch = (int'(sel_out_o) >= NCH - 1) ? CH_W'(NCH - 1) : CH_W'(sel_out_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q      <= GW'(ACQ_CYCLES);
      bip_prev_q <= 1'b0;
    end else begin
      bip_prev_q <= bip_out_o;
      if (bip_out_o != bip_prev_q)           gap_q <= '0;
      else if (gap_q != GW'(ACQ_CYCLES))     gap_q <= gap_q + 1'b1;
    end
  end

  // R12
  conv_sclk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_o && sclk_o));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!conv_o && !sclk_o && !word_valid_o));

  // R9
  ctrl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(sel_out_o) && $stable(bip_out_o)));

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o);

  // R7
  chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> (word_chan_o <= max_ch));

  // R10
  valid_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> busy_o);

  // R11
  acq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_o) |-> (int'(gap_q) >= ACQ_CYCLES - 1));
endmodule

bind mcadc_readout_ctrl mcadc_readout_ctrl_chk #(
  .NCH(NCH), .SEL_W(SEL_W), .ACQ_CYCLES(ACQ_CYCLES), .CH_W(CH_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .conv_o       (conv_o),
  .sclk_o       (sclk_o),
  .busy_o       (busy_o),
  .word_valid_o (word_valid_o),
  .word_chan_o  (word_chan_o),
  .sel_out_o    (sel_out_o),
  .bip_out_o    (bip_out_o)
);

// File: tb/mcadc_readout_ctrl_tb.sv
`timescale 1ns/1ps
module mcadc_readout_ctrl_tb_top;
  localparam int HALF = 2;
  localparam int CONV = 2;
  localparam int ACQ  = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  chan_sel_i = 3'd0;
  logic        bipolar_i = 1'b0;
  logic        sdata_i = 1'b0;
  logic        conv_o, sclk_o, bip_out_o, busy_o, word_valid_o, word_twos_o;
  logic [2:0]  sel_out_o;
  logic [13:0] word_data_o;
  logic [2:0]  word_chan_o;

  int checks = 0;
  int errors = 0;
  logic [13:0] exp_w [6];
  int   mdl_ptr = 0;
  logic last_bip = 1'b0;

  always #2 clk = ~clk;

  mcadc_readout_ctrl #(.SCLK_HALF(HALF), .CONV_CYCLES(CONV), .ACQ_CYCLES(ACQ)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_sel_i(chan_sel_i),
    .bipolar_i(bipolar_i), .sdata_i(sdata_i), .conv_o(conv_o), .sclk_o(sclk_o),
    .sel_out_o(sel_out_o), .bip_out_o(bip_out_o), .busy_o(busy_o),
    .word_valid_o(word_valid_o), .word_data_o(word_data_o),
    .word_chan_o(word_chan_o), .word_twos_o(word_twos_o)
  );

  // Converter model: restarts on the convert strobe, moves data on the clock's rising edge.
  // Each slot carries 14 result bits MSB first, then two junk ones (R6).
  always @(posedge sclk_o or posedge conv_o) begin
    if (conv_o) begin
      mdl_ptr = 0;
    end else begin
      if ((mdl_ptr / 16) < 6 && (mdl_ptr % 16) < 14)
        sdata_i = exp_w[mdl_ptr / 16][13 - (mdl_ptr % 16)];
      else
        sdata_i = 1'b1;
      mdl_ptr = mdl_ptr + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk(!busy_o && !conv_o && !sclk_o && !word_valid_o, "R1", "quiet in reset",
        {busy_o, conv_o, sclk_o, word_valid_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !conv_o && !sclk_o && !word_valid_o, "R1", "quiet after reset",
        {busy_o, conv_o, sclk_o, word_valid_o}, 0);
    last_bip = 1'b0;
  endtask

  task automatic run_txn(input logic [2:0] sel, input logic bip, input logic [13:0] base, input bit inject);
    int n, delay, width, rises, nw, cyc, last_vld;
    int exp_delay;
    bit prev_s, frozen_ok;
    logic [13:0] acc;
    n = (sel >= 3'd5) ? 6 : int'(sel) + 1;
    acc = base;
    for (int c = 0; c < 6; c++) begin
      exp_w[c] = acc;
      acc = acc + 14'h0a5b;
    end
    exp_delay = (bip != last_bip) ? 1 + ACQ : 1;
    last_bip = bip;
    @(negedge clk);
    start_i = 1'b1; chan_sel_i = sel; bipolar_i = bip;
    @(negedge clk);
    start_i = 1'b0;
    // R10
    chk(busy_o, "R10", "busy after start", int'(busy_o), 1);
    delay = 1;
    while (!conv_o && delay < 200) begin
      @(negedge clk);
      delay++;
    end
    // R2 / R11
    chk(delay == exp_delay, (exp_delay > 1) ? "R11" : "R2", "strobe latency", delay, exp_delay);
    width = 0;
    while (conv_o && width < 50) begin
      chk(!sclk_o, "R2", "clock low in strobe", int'(sclk_o), 0);
      width++;
      @(negedge clk);
    end
    chk(width == CONV, "R2", "strobe width", width, CONV);
    rises = 0; nw = 0; cyc = 0; last_vld = -5; prev_s = 1'b0; frozen_ok = 1'b1;
    while (busy_o && cyc < 2000) begin
      if (sclk_o && !prev_s) rises++;
      prev_s = sclk_o;
      if (sel_out_o != sel || bip_out_o != bip) frozen_ok = 1'b0;
      if (word_valid_o) begin
        // R5 / R6
        chk(word_data_o == exp_w[nw % 6], "R6", "word data", int'(word_data_o), int'(exp_w[nw % 6]));
        // R7
        chk(int'(word_chan_o) == nw, "R7", "channel tag", int'(word_chan_o), nw);
        // R8
        chk(word_twos_o == bip, "R8", "format flag", int'(word_twos_o), int'(bip));
        nw++;
        last_vld = cyc;
      end
      if (inject && cyc == 40) begin
        start_i = 1'b1; chan_sel_i = ~sel; bipolar_i = ~bip;
      end else if (inject && cyc == 41) begin
        start_i = 1'b0; chan_sel_i = sel; bipolar_i = bip;
      end
      @(negedge clk);
      cyc++;
    end
    chk(rises == 16 * n, "R4", "clock rises", rises, 16 * n);
    chk(nw == n, "R3", "word count", nw, n);
    chk(frozen_ok, "R9", "controls frozen", int'(frozen_ok), 1);
    chk(last_vld == cyc - 1, "R10", "busy drop after last word", last_vld, cyc - 1);
    chk(!word_valid_o && !sclk_o, "R12", "idle after txn", {word_valid_o, sclk_o}, 0);
  endtask

  // {code, polarity, base word}
  localparam logic [17:0] VEC [9] = '{
    {3'd0, 1'b0, 14'h1234},
    {3'd1, 1'b0, 14'h3fff},
    {3'd2, 1'b1, 14'h2001},
    {3'd4, 1'b1, 14'h0000},
    {3'd5, 1'b1, 14'h1555},
    {3'd6, 1'b0, 14'h2aaa},
    {3'd7, 1'b0, 14'h0f0f},
    {3'd3, 1'b1, 14'h3c3c},
    {3'd3, 1'b1, 14'h0101}
  };

  initial begin
    do_reset();
    for (int i = 0; i < 9; i++)
      run_txn(VEC[i][17:15], VEC[i][14], VEC[i][13:0], 1'b0);
    // R9: start request during busy is ignored
    run_txn(3'd2, 1'b0, 14'h0abc, 1'b1);
    repeat (3) @(negedge clk);
    chk(!busy_o, "R9", "no extra transaction", int'(busy_o), 0);
    // R1: reset in the middle of a readout
    @(negedge clk);
    start_i = 1'b1; chan_sel_i = 3'd7; bipolar_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    repeat (30) @(negedge clk);
    do_reset();
    // Polarity held value returns to 0 after reset (R11)
    run_txn(3'd0, 1'b1, 14'h2468, 1'b0);
    run_txn(3'd5, 1'b1, 14'h1357, 1'b0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end
endmodule